// File: doc/BRIEF.md
# Low-Power Mode and Emulation Sequencer

This block decides, cycle by cycle, whether a small controller core is running, idling, powered down, waking from power-down, held in reset or parked in on-circuit emulation. It gates the CPU clock and the oscillator, raises the register-reset strobe when the reset pin has been qualified, and tells the pad ring how to treat the address/data port, the other ports and the two bus strobes in each state.

The reset pin is sampled once per machine cycle, a machine cycle being `MC_DIV` oscillator clocks, and only while the oscillator runs. Software enters idle or power-down with one-cycle request pulses. Idle ends on any enabled interrupt. Power-down ends in two phases: a low level on a wake-qualified external interrupt pin restarts the oscillator, and execution resumes only after a programmable settling count has elapsed and the pin has gone high again. Emulation is chosen at reset release from the levels of the address-latch and program-strobe pins.

Top module: `pwr_emu_ctrl`

## Requirements
- R1: `sfr_rst` rises only after `rst_pin` has been seen high at two consecutive machine-cycle ticks (one tick every `MC_DIV` clocks while the oscillator runs). A pulse covering one tick causes no reset. `sfr_rst` stays high until a tick samples the pin low.
- R2: At reset release, if the last reset-time tick saw `ale_pin` low with `psen_pin` high and `ale_pin` is still low at the release tick, the block enters emulation: `emu_mode`=1, `cpu_clk_en`=0, `osc_en`=1, `port0_mode`=2 (float), `portx_mode`=1 (weak pullup), `strobe_mode`=3 (weak high). Otherwise it enters run mode with `cpu_clk_en`=1.
- R3: Emulation ignores idle requests, power-down requests and interrupts. It is left only through a qualified reset whose release sees `ale_pin` high.
- R4: `idle_req` in run mode stops the CPU clock, keeps the oscillator on, sets `strobe_mode`=1 (held high), `portx_mode`=0 (driven) and `port0_mode`=2 when `ext_exec`=1, 0 otherwise.
- R5: In idle, `irq_any` returns the block to run mode at the next clock edge.
- R6: `pd_req` in run mode stops both the CPU clock and the oscillator, with `strobe_mode`=2 (held low) and the port modes as in idle. When both requests arrive in the same cycle, power-down wins.
- R7: In power-down, only a pin `i` with `int_en[i]`=1 and `int_level[i]`=1 (level-triggered) wakes the block when `int_n[i]` is low. A low pin that is disabled or edge-configured leaves the oscillator stopped.
- R8: A qualifying low pin turns `osc_en` on at the next edge. `cpu_clk_en` returns `stab_cycles`+1 clocks after that, if every qualified pin is high by then. Otherwise it returns at the first edge at which they are all high, and stays off while one is held low.
- R9: `rst_pin` high during power-down restarts the oscillator. The reset is then qualified as in R1, and its release leads to run mode.
- R10: After `rst_ni` the block holds in reset: `cpu_clk_en`=0, `osc_en`=1, `sfr_rst`=0, and it moves to run mode at the first tick that sees `rst_pin` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous power-on reset of the sequencer flops, active low |
| rst_pin | input | 1 | Reset pin level, active high |
| idle_req | input | 1 | Software idle request pulse |
| pd_req | input | 1 | Software power-down request pulse |
| irq_any | input | 1 | Some enabled interrupt is pending |
| int_n | input | N_EXT | External interrupt pin levels, active low |
| int_en | input | N_EXT | External interrupt enables |
| int_level | input | N_EXT | 1 = level-triggered, 0 = edge-triggered |
| ale_pin | input | 1 | Address-latch strobe pin level |
| psen_pin | input | 1 | Program-strobe pin level |
| ext_exec | input | 1 | Code runs from external program memory |
| stab_cycles | input | STAB_W | Oscillator settling count for interrupt wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Qualified register reset strobe |
| port0_mode | output | 2 | Address/data port: 0 drive, 1 weak, 2 float |
| portx_mode | output | 2 | Other ports: 0 drive, 1 weak, 2 float |
| strobe_mode | output | 2 | Bus strobes: 0 clocked, 1 high, 2 low, 3 weak high |
| emu_mode | output | 1 | Emulation mode active |

## Verification
The checker watches, every cycle, that the oscillator only stops right after a power-down request, that `sfr_rst` only rises after the pin was high, that emulation is entered with the address-latch pin low and left only under reset, and that an interrupt in idle, or the settling count in a wake, gates the CPU clock back on. The exact settling length, the two-tick reset filter against a one-tick pulse, the strap combinations that must not reach emulation, and the full pin-mode tables for each state can only be shown by the bench's directed and random scenarios.

// File: rtl/pwr_emu_pkg.sv
package pwr_emu_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_RUN   = 3'd1,
        ST_IDLE  = 3'd2,
        ST_PD    = 3'd3,
        ST_WAKE  = 3'd4,
        ST_EMU   = 3'd5
    } pwr_state_e;

    typedef enum logic [1:0] {
        PM_DRIVE = 2'd0,
        PM_WEAK  = 2'd1,
        PM_FLOAT = 2'd2
    } port_mode_e;

    typedef enum logic [1:0] {
        SM_CLOCKED = 2'd0,
        SM_HIGH    = 2'd1,
        SM_LOW     = 2'd2,
        SM_WEAK    = 2'd3
    } strobe_mode_e;

endpackage

// File: rtl/mc_tick_gen.sv
module mc_tick_gen #(
    parameter int MC_DIV = 4
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (MC_DIV > 2) ? $clog2(MC_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(MC_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
    parameter int RST_MC = 2
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rst_pin,
    input  logic ale_pin,
    input  logic psen_pin,
    output logic active_o,
    output logic strap_o
);
    localparam int CW = $clog2(RST_MC + 1);
    localparam logic [CW-1:0] FULL = CW'(RST_MC);
    localparam logic [CW-1:0] NEAR = CW'(RST_MC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
        logic          strap;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (tick_i) begin
            if (rst_pin) begin
                if (q_q.cnt != FULL) q_d.cnt = q_q.cnt + 1'b1;
                q_d.active = (q_q.cnt >= NEAR);
                q_d.strap  = !ale_pin && psen_pin;
            end else begin
                q_d.cnt    = '0;
                q_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign active_o = q_q.active;
    assign strap_o  = q_q.strap;
endmodule

// File: rtl/pd_wake_timer.sv
module pd_wake_timer #(
    parameter int N_EXT  = 2,
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              count_i,
    input  logic [STAB_W-1:0] stab_cycles,
    input  logic [N_EXT-1:0]  int_n,
    input  logic [N_EXT-1:0]  int_en,
    input  logic [N_EXT-1:0]  int_level,
    output logic              wake_req_o,
    output logic              pins_high_o,
    output logic              stab_done_o
);
    localparam logic [STAB_W-1:0] CMAX = '1;

    logic [N_EXT-1:0] low_q, ok_q;
    logic [STAB_W-1:0] cnt_d, cnt_q;

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        logic qual;
        assign qual     = int_en[i] && int_level[i];
        assign low_q[i] = qual && !int_n[i];
        assign ok_q[i]  = !qual || int_n[i];
    end

    assign wake_req_o  = |low_q;
    assign pins_high_o = &ok_q;

    always_comb begin
        cnt_d = '0;
        if (count_i) cnt_d = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign stab_done_o = count_i && (cnt_q >= stab_cycles);
endmodule

// File: rtl/pwr_emu_ctrl.sv
module pwr_emu_ctrl
    import pwr_emu_pkg::*;
#(
    parameter int MC_DIV = 4,
    parameter int RST_MC = 2,
    parameter int N_EXT  = 2,
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              rst_pin,
    input  logic              idle_req,
    input  logic              pd_req,
    input  logic              irq_any,
    input  logic [N_EXT-1:0]  int_n,
    input  logic [N_EXT-1:0]  int_en,
    input  logic [N_EXT-1:0]  int_level,
    input  logic              ale_pin,
    input  logic              psen_pin,
    input  logic              ext_exec,
    input  logic [STAB_W-1:0] stab_cycles,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              sfr_rst,
    output logic [1:0]        port0_mode,
    output logic [1:0]        portx_mode,
    output logic [1:0]        strobe_mode,
    output logic              emu_mode
);
    typedef struct packed {
        pwr_state_e state;
    } seq_t;

    seq_t s_d, s_q;

    logic tick, rst_active, strap_ok;
    logic wake_req, pins_high, stab_done;
    port_mode_e   p0_m, px_m;
    strobe_mode_e st_m;

    mc_tick_gen #(.MC_DIV(MC_DIV)) u_tick (
        .clk(clk), .rst_ni(rst_ni), .run_i(osc_en), .tick_o(tick)
    );

    rst_qualifier #(.RST_MC(RST_MC)) u_rstq (
        .clk(clk), .rst_ni(rst_ni), .tick_i(tick), .rst_pin(rst_pin),
        .ale_pin(ale_pin), .psen_pin(psen_pin),
        .active_o(rst_active), .strap_o(strap_ok)
    );

    pd_wake_timer #(.N_EXT(N_EXT), .STAB_W(STAB_W)) u_wake (
        .clk(clk), .rst_ni(rst_ni), .count_i(s_q.state == ST_WAKE),
        .stab_cycles(stab_cycles), .int_n(int_n), .int_en(int_en),
        .int_level(int_level), .wake_req_o(wake_req),
        .pins_high_o(pins_high), .stab_done_o(stab_done)
    );

    // next-state logic
    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_RESET: begin
                if (tick && !rst_pin) begin
                    s_d.state = (rst_active && strap_ok && !ale_pin) ? ST_EMU : ST_RUN;
                end
            end
            ST_RUN: begin
                if (pd_req)        s_d.state = ST_PD;
                else if (idle_req) s_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_any) s_d.state = ST_RUN;
            end
            ST_PD: begin
                if (rst_pin)       s_d.state = ST_RESET;
                else if (wake_req) s_d.state = ST_WAKE;
            end
            ST_WAKE: begin
                if (stab_done && pins_high) s_d.state = ST_RUN;
            end
            ST_EMU: begin
                s_d.state = ST_EMU;
            end
            default: s_d.state = ST_RESET;
        endcase
        if (rst_active && (s_q.state != ST_RESET)) s_d.state = ST_RESET;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{state: ST_RESET};
        else         s_q <= s_d;
    end

    // output decode from the registered state
    always_comb begin
        cpu_clk_en = 1'b0;
        osc_en     = 1'b1;
        emu_mode   = 1'b0;
        p0_m       = PM_DRIVE;
        px_m       = PM_DRIVE;
        st_m       = SM_CLOCKED;
        unique case (s_q.state)
            ST_RUN: cpu_clk_en = 1'b1;
            ST_IDLE: begin
                st_m = SM_HIGH;
                p0_m = ext_exec ? PM_FLOAT : PM_DRIVE;
            end
            ST_PD: begin
                osc_en = 1'b0;
                st_m   = SM_LOW;
                p0_m   = ext_exec ? PM_FLOAT : PM_DRIVE;
            end
            ST_WAKE: begin
                st_m = SM_LOW;
                p0_m = ext_exec ? PM_FLOAT : PM_DRIVE;
            end
            ST_EMU: begin
                emu_mode = 1'b1;
                p0_m     = PM_FLOAT;
                px_m     = PM_WEAK;
                st_m     = SM_WEAK;
            end
            default: ;
        endcase
    end

    assign sfr_rst     = rst_active;
    assign port0_mode  = p0_m;
    assign portx_mode  = px_m;
    assign strobe_mode = st_m;
endmodule

// File: rtl/pwr_emu_chk.sv
module pwr_emu_chk #(
    parameter int N_EXT = 2
) (
    input logic             clk,
    input logic             rst_ni,
    input logic             rst_pin,
    input logic             pd_req,
    input logic             irq_any,
    input logic             ale_pin,
    input logic [N_EXT-1:0] int_n,
    input logic [N_EXT-1:0] int_en,
    input logic [N_EXT-1:0] int_level,
    input logic             cpu_clk_en,
    input logic             osc_en,
    input logic             sfr_rst,
    input logic [1:0]       strobe_mode,
    input logic             emu_mode,
    input logic             stab_done
);
    logic any_wake_low;
    assign any_wake_low = |(int_en & int_level & ~int_n);

    // R6
    osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $fell(osc_en) |-> $past(pd_req));

    // R1
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(sfr_rst) |-> $past(rst_pin));

    // R2
    emu_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(emu_mode) |-> ($past(!ale_pin) && $past(sfr_rst)));

    // R3
    emu_exit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $fell(emu_mode) |-> sfr_rst);

    // R5
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (strobe_mode == 2'd1 && irq_any && !rst_pin && !sfr_rst) |=> cpu_clk_en);

    // R7
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!osc_en && !rst_pin && !any_wake_low) |=> !osc_en);

    // R8
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        ($rose(cpu_clk_en) && $past(strobe_mode) == 2'd2) |-> $past(stab_done));
endmodule

bind pwr_emu_ctrl pwr_emu_chk #(.N_EXT(N_EXT)) u_pwr_emu_chk (
    .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .pd_req(pd_req),
    .irq_any(irq_any), .ale_pin(ale_pin), .int_n(int_n), .int_en(int_en),
    .int_level(int_level), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .sfr_rst(sfr_rst), .strobe_mode(strobe_mode), .emu_mode(emu_mode),
    .stab_done(stab_done)
);

// File: tb/tb_pwr_emu_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_emu_ctrl;
    localparam int MC_DIV = 4;
    localparam int N_EXT  = 2;
    localparam int STAB_W = 8;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_any = 1'b0;
    logic [N_EXT-1:0] int_n = '1, int_en = '0, int_level = '0;
    logic ale_pin = 1'b1, psen_pin = 1'b1, ext_exec = 1'b0;
    logic [STAB_W-1:0] stab_cycles = '0;
    logic cpu_clk_en, osc_en, sfr_rst, emu_mode;
    logic [1:0] port0_mode, portx_mode, strobe_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit saw_rst;

    always #2 clk = ~clk;

    pwr_emu_ctrl #(.MC_DIV(MC_DIV), .N_EXT(N_EXT), .STAB_W(STAB_W)) dut (
        .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .idle_req(idle_req),
        .pd_req(pd_req), .irq_any(irq_any), .int_n(int_n), .int_en(int_en),
        .int_level(int_level), .ale_pin(ale_pin), .psen_pin(psen_pin),
        .ext_exec(ext_exec), .stab_cycles(stab_cycles),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .sfr_rst(sfr_rst),
        .port0_mode(port0_mode), .portx_mode(portx_mode),
        .strobe_mode(strobe_mode), .emu_mode(emu_mode)
    );

    always @(negedge clk) if (sfr_rst) saw_rst = 1'b1;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode: 0 run, 1 idle, 2 power-down, 3 emulation
    function automatic int exp_pins(input int mode, input bit ext);
        int p0, px, st;
        p0 = 0; px = 0; st = 0;
        case (mode)
            1: begin st = 1; p0 = ext ? 2 : 0; end
            2: begin st = 2; p0 = ext ? 2 : 0; end
            3: begin st = 3; p0 = 2; px = 1; end
            default: ;
        endcase
        return p0 * 16 + px * 4 + st;
    endfunction

    function automatic int exp_mode(input bit idl, input bit pd);
        return pd ? 2 : (idl ? 1 : 0);
    endfunction

    function automatic int act_pins();
        return int'(port0_mode) * 16 + int'(portx_mode) * 4 + int'(strobe_mode);
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reset_pulse(input int mcs, input bit ale, input bit psen, input bit ale_rel);
        saw_rst = 1'b0;
        rst_pin = 1'b1; ale_pin = ale; psen_pin = psen;
        cyc(mcs * MC_DIV);
        rst_pin = 1'b0; ale_pin = ale_rel;
        cyc(2 * MC_DIV);
        ale_pin = 1'b1; psen_pin = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_req(input bit idl, input bit pd);
        idle_req = idl; pd_req = pd;
        @(negedge clk);
        idle_req = 1'b0; pd_req = 1'b0;
    endtask

    initial begin
        int k, s, n;
        bit idl, pd, ext;
        void'($urandom(32'd20240611));
        cyc(3);
        // R10 held in reset state
        check("R10 cpu_clk_en in reset", cpu_clk_en, 0);
        check("R10 osc_en in reset", osc_en, 1);
        check("R10 sfr_rst in reset", sfr_rst, 0);
        rst_ni = 1'b1;
        cyc(2 * MC_DIV);
        check("R10 run after release", cpu_clk_en, 1);

        // R1 one-tick pulse ignored, three-tick pulse resets
        reset_pulse(1, 1'b1, 1'b1, 1'b1);
        check("R1 short pulse no reset", saw_rst, 0);
        check("R1 short pulse keeps run", cpu_clk_en, 1);
        reset_pulse(3, 1'b1, 1'b1, 1'b1);
        check("R1 long pulse resets", saw_rst, 1);
        check("R1 run after reset", cpu_clk_en, 1);
        check("R2 no emu with ALE high", emu_mode, 0);

        // R2 strap variants
        reset_pulse(3, 1'b0, 1'b0, 1'b0);
        check("R2 PSEN low blocks emu", emu_mode, 0);
        reset_pulse(3, 1'b0, 1'b1, 1'b1);
        check("R2 ALE high at release blocks emu", emu_mode, 0);
        reset_pulse(3, 1'b0, 1'b1, 1'b0);
        check("R2 emu entered", emu_mode, 1);
        check("R2 emu cpu off", cpu_clk_en, 0);
        check("R2 emu osc on", osc_en, 1);
        check("R2 emu pins", act_pins(), exp_pins(3, 1'b0));

        // R3 requests ignored in emulation
        pulse_req(1'b1, 1'b1);
        irq_any = 1'b1; cyc(2); irq_any = 1'b0;
        int_en = '1; int_level = '1; int_n = '0; cyc(2); int_n = '1;
        check("R3 emu kept", emu_mode, 1);
        check("R3 emu osc kept", osc_en, 1);
        reset_pulse(3, 1'b1, 1'b1, 1'b1);
        check("R3 emu left by reset", emu_mode, 0);
        check("R3 run after emu", cpu_clk_en, 1);

        // R9 reset during power-down
        pulse_req(1'b0, 1'b1);
        check("R6 osc off", osc_en, 0);
        reset_pulse(4, 1'b1, 1'b1, 1'b1);
        check("R9 reset qualified from power-down", saw_rst, 1);
        check("R9 run after power-down reset", cpu_clk_en, 1);

        // R8 held-low pin delays resume
        stab_cycles = 8'd3; int_en = 2'b01; int_level = 2'b01;
        pulse_req(1'b0, 1'b1);
        int_n = 2'b10;
        cyc(1);
        check("R8 osc restarts on low", osc_en, 1);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cpu_clk_en) k++;
        end
        check("R8 held low keeps cpu stopped", k, 0);
        int_n = '1;
        cyc(1);
        check("R8 resume on rising pin", cpu_clk_en, 1);

        // random sequences
        for (int it = 0; it < 40; it++) begin
            idl = 1'($urandom);
            pd  = 1'($urandom);
            ext = 1'($urandom);
            ext_exec = ext;
            pulse_req(idl, pd);
            check("R4/R6 cpu state", cpu_clk_en, (exp_mode(idl, pd) == 0) ? 1 : 0);
            check("R6 osc state", osc_en, (exp_mode(idl, pd) == 2) ? 0 : 1);
            check("R4/R6 pin modes", act_pins(), exp_pins(exp_mode(idl, pd), ext));
            if (exp_mode(idl, pd) == 1) begin
                irq_any = 1'b1; @(negedge clk); irq_any = 1'b0;
                check("R5 idle exit", cpu_clk_en, 1);
            end else if (exp_mode(idl, pd) == 2) begin
                k = int'($urandom_range(0, N_EXT - 1));
                // R7 non-qualified pin
                int_en = '0; int_level = '0;
                int_en[k] = 1'($urandom); int_level[k] = !int_en[k];
                int_n[k] = 1'b0; cyc(3); int_n = '1;
                check("R7 unqualified pin ignored", osc_en, 0);
                s = int'($urandom_range(0, 15));
                stab_cycles = STAB_W'(s);
                int_en[k] = 1'b1; int_level[k] = 1'b1;
                int_n[k] = 1'b0;
                @(negedge clk);
                int_n = '1;
                check("R8 osc on after low", osc_en, 1);
                n = 0;
                while (!cpu_clk_en && n < 300) begin @(negedge clk); n++; end
                check("R8 settle length", n, s + 1);
                int_en = '0; int_level = '0;
            end
            ext_exec = 1'b0;
            cyc(1);
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule